// File: doc/BRIEF.md
# Asynchronous Static Memory Access Sequencer

This block runs single read and write accesses to an external asynchronous static memory (SRAM, PSRAM or NOR flash) and counts every phase in system clock cycles. A requester presents an address, a direction and write data, then waits for a done pulse. On a read, the word fetched from the memory comes back with that pulse.

Each access has up to three phases: address setup, address hold and data. Three software timing fields set how long each phase lasts. A mode bit selects one of two buses. The first is a separate bus, where the address pins and the data pins are distinct. The second is a shared bus, where the data pins carry the low address bits first, an address-valid strobe marks that address, and an address-hold phase follows before the data phase.

The timing fields and the mode bit live in a small configuration register. The sequencer copies them when it accepts a request, so software may rewrite the register at any time.

Top module: `amem_seq_top`

## Requirements
- R1: After reset, chip select, output enable, write enable and the address-valid strobe are high (inactive), and busy and done are low. The timing fields reset to their largest values (setup 15, hold 15, data 255) and the mode bit resets to 0, the separate bus. An access made with these values keeps chip select low for 270 cycles.
- R2: On the separate bus, a setup field of N (0 to 15) gives N setup cycles. With N = 0 the data phase starts in the first cycle of the access.
- R3: On the shared bus (mode bit 1), the setup phase lasts the field value, or 1 cycle when the field is 0.
- R4: The hold phase exists only on the shared bus. There it lasts the hold field value, or 1 cycle when the field is 0. On the separate bus, chip select stays low for exactly setup plus data cycles.
- R5: The data phase lasts the 8-bit data field value (1 to 255), or 1 cycle when the field is 0.
- R6: Output enable is low only during the data phase of a read, and write enable is low only during the data phase of a write. Each is low for the whole data phase, and the two are never low together.
- R7: The address-valid strobe is low exactly during the setup cycles and at no other time.
- R8: On the shared bus, the data pins are driven with the low address bits through setup and hold. In the data phase they are released on reads and driven with the write data on writes. On the separate bus, the data pins are driven only during the data phase of a write, and then carry the write data.
- R9: On a read, the data pins are sampled in the last data cycle, and the sampled word appears on rdata in the same cycle as done.
- R10: The timing fields and the mode bit are copied when a request is accepted. A configuration write made during an access changes only later accesses.
- R11: Done is a single-cycle pulse. It comes in the cycle after the last data cycle, S+H+D+1 cycles after the accepting clock edge, with chip select already high. Chip select then stays high for at least one cycle before the next access begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the timing register |
| cfg_mux | input | 1 | Bus mode to write: 1 = shared address/data bus |
| cfg_setup | input | 4 | Address-setup length to write |
| cfg_hold | input | 4 | Address-hold length to write |
| cfg_data | input | 8 | Data-phase length to write |
| req_valid | input | 1 | Access request, taken only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-access pulse |
| rdata | output | DATA_W | Data returned by the last read |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_adv_n | output | 1 | Address-valid strobe, active low |
| mem_addr | output | ADDR_W | Address pins |
| mem_dq_out | output | DATA_W | Value driven on the data pins |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_dq_in | input | DATA_W | Value read from the data pins |

## Verification
The accepting edge is the first rising edge at which req_valid is seen while the block is idle. Every memory pin is registered from the next state, so the first phase is visible one cycle after that edge, and done with rdata arrives S+H+D+1 cycles after it. The bench drives and samples only on falling edges and lowers the request one cycle after it is accepted. It then counts, cycle by cycle, how long each strobe and each data-pin state lasts, and compares the counts and the cycle in which done appears with values worked out from the effective phase lengths. The checks on the gap after done and on the configuration snapshot are made at fixed offsets from that same accepting edge.

// File: rtl/amem_pkg.sv
package amem_pkg;

  parameter int SETUP_W = 4;
  parameter int HOLD_W  = 4;
  parameter int DPH_W   = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HOLD,
    ST_DATA,
    ST_GAP
  } amem_state_e;

  typedef struct packed {
    logic               mux;
    logic [SETUP_W-1:0] setup;
    logic [HOLD_W-1:0]  hold;
    logic [DPH_W-1:0]   data;
  } amem_timing_t;

endpackage

// File: rtl/amem_cfg_regs.sv
module amem_cfg_regs
  import amem_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  amem_timing_t wr_val,
  output amem_timing_t cfg_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q.mux   <= 1'b0;
      cfg_q.setup <= '1;
      cfg_q.hold  <= '1;
      cfg_q.data  <= '1;
    end else if (we) begin
      cfg_q <= wr_val;
    end
  end

endmodule

// File: rtl/amem_len_fix.sv
module amem_len_fix
  import amem_pkg::*;
(
  input  amem_timing_t raw,
  output amem_timing_t eff
);

  logic setup_zero;
  logic hold_zero;
  logic data_zero;

  assign setup_zero = (raw.setup == '0);
  assign hold_zero  = (raw.hold == '0);
  assign data_zero  = (raw.data == '0);

  always_comb begin
    eff     = raw;
    // shared bus needs at least one address cycle
    if (raw.mux && setup_zero) eff.setup = SETUP_W'(1);
    // reserved zero values run as one cycle
    if (hold_zero) eff.hold = HOLD_W'(1);
    if (data_zero) eff.data = DPH_W'(1);
  end

endmodule

// File: rtl/amem_phase_ctrl.sv
module amem_phase_ctrl
  import amem_pkg::*;
#(
  parameter int CNT_W = DPH_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  amem_timing_t eff,
  output amem_state_e  state_q,
  output amem_state_e  state_d,
  output logic         mux_d,
  output logic         last_data
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  amem_timing_t     snap_q;
  amem_timing_t     use_t;
  logic [CNT_W-1:0] ld_setup;
  logic [CNT_W-1:0] ld_hold;
  logic [CNT_W-1:0] ld_data;
  logic             cnt_end;

  assign use_t    = start ? eff : snap_q;
  assign ld_setup = CNT_W'(use_t.setup) - CNT_W'(1);
  assign ld_hold  = CNT_W'(use_t.hold) - CNT_W'(1);
  assign ld_data  = CNT_W'(use_t.data) - CNT_W'(1);
  assign cnt_end  = (cnt_q == '0);
  assign mux_d    = use_t.mux;
  assign last_data = (state_q == ST_DATA) && cnt_end;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!cnt_end) cnt_d = cnt_q - CNT_W'(1);
    case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (start) begin
          if (use_t.setup != '0) begin
            state_d = ST_SETUP;
            cnt_d   = ld_setup;
          end else begin
            state_d = ST_DATA;
            cnt_d   = ld_data;
          end
        end
      end
      ST_SETUP: begin
        if (cnt_end) begin
          if (use_t.mux) begin
            state_d = ST_HOLD;
            cnt_d   = ld_hold;
          end else begin
            state_d = ST_DATA;
            cnt_d   = ld_data;
          end
        end
      end
      ST_HOLD: begin
        if (cnt_end) begin
          state_d = ST_DATA;
          cnt_d   = ld_data;
        end
      end
      ST_DATA: begin
        if (cnt_end) state_d = ST_GAP;
      end
      ST_GAP: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      snap_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (start) snap_q <= eff;
    end
  end

endmodule

// File: rtl/amem_pin_drv.sv
module amem_pin_drv
  import amem_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  amem_state_e       state_d,
  input  logic              mux_d,
  input  logic              wr_d,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic [DATA_W-1:0] wdata_d,
  output logic              busy,
  output logic              done,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_adv_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe
);

  logic [DATA_W-1:0] addr_on_bus;
  logic              in_access;
  logic              in_addr_ph;
  logic              in_data_ph;

  generate
    if (ADDR_W >= DATA_W) begin : g_addr_trunc
      assign addr_on_bus = addr_d[DATA_W-1:0];
    end else begin : g_addr_ext
      assign addr_on_bus = {{(DATA_W-ADDR_W){1'b0}}, addr_d};
    end
  endgenerate

  assign in_access  = (state_d == ST_SETUP) || (state_d == ST_HOLD) ||
                      (state_d == ST_DATA);
  assign in_addr_ph = (state_d == ST_SETUP) || (state_d == ST_HOLD);
  assign in_data_ph = (state_d == ST_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      mem_cs_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_adv_n  <= 1'b1;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
    end else begin
      busy      <= (state_d != ST_IDLE);
      done      <= (state_d == ST_GAP);
      mem_cs_n  <= !in_access;
      mem_oe_n  <= !(in_data_ph && !wr_d);
      mem_we_n  <= !(in_data_ph && wr_d);
      mem_adv_n <= !(state_d == ST_SETUP);
      mem_addr  <= addr_d;
      mem_dq_oe <= (mux_d && in_addr_ph) || (in_data_ph && wr_d);
      if (in_data_ph) mem_dq_out <= wdata_d;
      else            mem_dq_out <= addr_on_bus;
    end
  end

endmodule

// File: rtl/amem_seq_top.sv
module amem_seq_top
  import amem_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic               cfg_mux,
  input  logic [SETUP_W-1:0] cfg_setup,
  input  logic [HOLD_W-1:0]  cfg_hold,
  input  logic [DPH_W-1:0]   cfg_data,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               busy,
  output logic               done,
  output logic [DATA_W-1:0]  rdata,
  output logic               mem_cs_n,
  output logic               mem_oe_n,
  output logic               mem_we_n,
  output logic               mem_adv_n,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_dq_out,
  output logic               mem_dq_oe,
  input  logic [DATA_W-1:0]  mem_dq_in
);

  amem_timing_t      cfg_wr;
  amem_timing_t      cfg_q;
  amem_timing_t      cfg_eff;
  amem_state_e       state_q;
  amem_state_e       state_d;
  logic              mux_d;
  logic              last_data;
  logic              start;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              wr_d;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] wdata_d;
  logic [DATA_W-1:0] rdata_q;

  assign cfg_wr = '{mux: cfg_mux, setup: cfg_setup, hold: cfg_hold, data: cfg_data};

  amem_cfg_regs u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .wr_val(cfg_wr),
    .cfg_q (cfg_q)
  );

  amem_len_fix u_fix (
    .raw(cfg_q),
    .eff(cfg_eff)
  );

  assign start = req_valid && (state_q == ST_IDLE);

  amem_phase_ctrl #(.CNT_W(DPH_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .eff      (cfg_eff),
    .state_q  (state_q),
    .state_d  (state_d),
    .mux_d    (mux_d),
    .last_data(last_data)
  );

  assign wr_d    = start ? req_write : wr_q;
  assign addr_d  = start ? req_addr  : addr_q;
  assign wdata_d = start ? req_wdata : wdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (start) begin
        wr_q    <= req_write;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (last_data && !wr_q) rdata_q <= mem_dq_in;
    end
  end

  assign rdata = rdata_q;

  amem_pin_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk       (clk),
    .rst       (rst),
    .state_d   (state_d),
    .mux_d     (mux_d),
    .wr_d      (wr_d),
    .addr_d    (addr_d),
    .wdata_d   (wdata_d),
    .busy      (busy),
    .done      (done),
    .mem_cs_n  (mem_cs_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_adv_n (mem_adv_n),
    .mem_addr  (mem_addr),
    .mem_dq_out(mem_dq_out),
    .mem_dq_oe (mem_dq_oe)
  );

endmodule

// File: rtl/amem_seq_chk.sv
module amem_seq_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              mem_cs_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_adv_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_dq_oe
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (mem_cs_n && !done));

  // R6
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n));

  // R6
  strobe_in_cs_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_oe_n || !mem_we_n || !mem_adv_n) |-> !mem_cs_n);

  // R7
  adv_not_data_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_adv_n |-> (mem_oe_n && mem_we_n));

  // R8
  read_release_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> !mem_dq_oe);

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11
  done_cs_high_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> mem_cs_n);

  // R11
  cs_end_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_cs_n) |-> done);

  // R2
  addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

endmodule

bind amem_seq_top amem_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .done     (done),
  .mem_cs_n (mem_cs_n),
  .mem_oe_n (mem_oe_n),
  .mem_we_n (mem_we_n),
  .mem_adv_n(mem_adv_n),
  .mem_addr (mem_addr),
  .mem_dq_oe(mem_dq_oe)
);

// File: tb/tb_amem_seq_top.sv
module tb_amem_seq_top;

  localparam int AW = 20;
  localparam int DW = 16;
  localparam logic [15:0] RD_KEY = 16'h5A3C;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic          cfg_mux = 1'b0;
  logic [3:0]    cfg_setup = '0;
  logic [3:0]    cfg_hold = '0;
  logic [7:0]    cfg_data = '0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          busy, done;
  logic [DW-1:0] rdata;
  logic          mem_cs_n, mem_oe_n, mem_we_n, mem_adv_n, mem_dq_oe;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dq_out;
  logic [DW-1:0] mem_dq_in;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  assign mem_dq_in = !mem_oe_n ? (mem_addr[15:0] ^ RD_KEY) : 16'h0000;

  amem_seq_top #(.ADDR_W(AW), .DATA_W(DW)) dut (.*);

  typedef struct {
    int cs; int adv; int oe; int we; int dqa; int dqw; int dqoe; int cyc;
    logic [15:0] rd; logic done_after;
  } res_t;

  // {mux, write, setup, hold, data, addr, wdata}
  localparam int VW = 54;
  localparam int NV = 8;
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0, 1'b0, 4'd2,  4'd3,  8'd4,   20'h12345, 16'h0000},
    {1'b0, 1'b1, 4'd0,  4'd5,  8'd1,   20'h0ABCD, 16'hBEEF},
    {1'b1, 1'b0, 4'd0,  4'd0,  8'd0,   20'hF0F0F, 16'h0000},
    {1'b1, 1'b1, 4'd3,  4'd2,  8'd5,   20'h13579, 16'hC0DE},
    {1'b0, 1'b0, 4'd0,  4'd0,  8'd0,   20'h2468A, 16'h0000},
    {1'b1, 1'b0, 4'd15, 4'd15, 8'd7,   20'h55AA5, 16'h0000},
    {1'b0, 1'b1, 4'd15, 4'd1,  8'd255, 20'h00777, 16'h1234},
    {1'b1, 1'b1, 4'd1,  4'd1,  8'd1,   20'hFFFFF, 16'hA5A5}
  };

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic write_cfg(input logic m, input logic [3:0] s, input logic [3:0] h, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_mux = m; cfg_setup = s; cfg_hold = h; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_access(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                            output res_t r);
    r = '{0, 0, 0, 0, 0, 0, 0, 0, 16'h0, 1'b0};
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      r.cyc++;
      if (!mem_cs_n) r.cs++;
      if (!mem_adv_n) r.adv++;
      if (!mem_oe_n) r.oe++;
      if (!mem_we_n) r.we++;
      if (mem_dq_oe) r.dqoe++;
      if (mem_dq_oe && mem_oe_n && mem_we_n && mem_dq_out == a[15:0]) r.dqa++;
      if (mem_dq_oe && !mem_we_n && mem_dq_out == wd) r.dqw++;
      if (done) begin
        r.rd = rdata;
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    r.done_after = done;
  endtask

  task automatic check_res(input string tag, input logic m, input logic wr, input int se,
                           input int he, input int de, input logic [AW-1:0] a, input res_t r);
    chk(tag, "setup/adv cycles", r.adv, se);
    chk("R4", "chip select cycles", r.cs, se + he + de);
    chk("R5", "data strobe cycles", r.oe + r.we, de);
    chk("R6", "oe cycles", r.oe, wr ? 0 : de);
    chk("R6", "we cycles", r.we, wr ? de : 0);
    chk("R8", "address on dq cycles", r.dqa, m ? se + he : 0);
    chk("R8", "write data on dq cycles", r.dqw, wr ? de : 0);
    chk("R8", "dq drive cycles", r.dqoe, (m ? se + he : 0) + (wr ? de : 0));
    chk("R11", "done latency", r.cyc, se + he + de + 1);
    chk("R11", "done one cycle", int'(r.done_after), 0);
    if (!wr) chk("R9", "read data", int'(r.rd), int'(a[15:0] ^ RD_KEY));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    res_t r;
    int gap;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "cs_n", int'(mem_cs_n), 1);
    chk("R1", "oe_n", int'(mem_oe_n), 1);
    chk("R1", "we_n", int'(mem_we_n), 1);
    chk("R1", "adv_n", int'(mem_adv_n), 1);
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "done", int'(done), 0);
    // R1 default fields: separate bus, setup 15, data 255
    run_access(1'b0, 20'h0C0DE, 16'h0, r);
    chk("R1", "default cs cycles", r.cs, 270);
    chk("R1", "default setup cycles", r.adv, 15);
    chk("R1", "default data cycles", r.oe, 255);

    for (int v = 0; v < NV; v++) begin
      logic m, wr;
      logic [3:0] s, h;
      logic [7:0] d;
      logic [AW-1:0] a;
      logic [DW-1:0] wd;
      int se, he, de;
      {m, wr, s, h, d, a, wd} = VEC[v];
      se = (m && s == 0) ? 1 : int'(s);
      he = m ? ((h == 0) ? 1 : int'(h)) : 0;
      de = (d == 0) ? 1 : int'(d);
      write_cfg(m, s, h, d);
      run_access(wr, a, wd, r);
      check_res(m ? "R3" : "R2", m, wr, se, he, de, a, r);
    end

    // R10: config rewritten during an access affects only the next one
    write_cfg(1'b0, 4'd0, 4'd1, 8'd3);
    fork
      run_access(1'b0, 20'h01111, 16'h0, r);
      begin
        @(negedge clk);
        @(negedge clk);
        cfg_we = 1'b1; cfg_mux = 1'b0; cfg_setup = 4'd0; cfg_hold = 4'd1; cfg_data = 8'd20;
        @(negedge clk);
        cfg_we = 1'b0;
      end
    join
    chk("R10", "data cycles of running access", r.oe, 3);
    run_access(1'b0, 20'h02222, 16'h0, r);
    chk("R10", "data cycles of next access", r.oe, 20);

    // R11: request held after done; chip select high before the next access
    write_cfg(1'b0, 4'd1, 4'd1, 8'd2);
    run_access(1'b1, 20'h03333, 16'h7777, r);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 20'h04444;
    gap = 0;
    for (int i = 0; i < 50; i++) begin
      if (!mem_cs_n) break;
      gap++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk("R11", "cs high before next access >= 1", int'(gap >= 1), 1);
    chk("R11", "next access started", int'(mem_cs_n), 0);
    for (int i = 0; i < 50; i++) begin
      if (done) break;
      @(negedge clk);
    end
    chk("R9", "back-to-back read data", int'(rdata), int'(16'h4444 ^ RD_KEY));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule